// File: doc/BRIEF.md
# Card-Select Bus Master with Per-Select Timing

This block sits on the processor card. It takes byte or word read and write requests from the internal side and runs them as cycles on a bus with three card selects. Each request carries a byte address, a size flag, a write flag, write data and a select index (0 to 2). The block turns the byte address into the word address the bus carries. It steers write bytes onto the correct half of the data bus and pulls an odd byte read down into the low byte of the result.

Cards on the bus run at different speeds and need different idle gaps, so each select has its own timing. A wait-state count W sets how long the cycle stays active, and a recovery count R sets how long the block holds off after the cycle. Both counts are 4-bit and measured in system clocks, and both arrive on static configuration inputs. The external wait input is not used: only W sets the cycle length. Each cycle runs as a fixed sequence of three phases: request accepted, active phase, recovery.

Top module: `cs_bus_master`

## Requirements
- R1: While reset is held and after it is released, every select, the read strobe and both write strobes are high. `reqReady` is 1, and `busDataOe` and `rspValid` are 0.
- R2: During a cycle exactly one select is low: the one with index `reqSel` (0, 1 or 2). The other two stay high.
- R3: `busAddr` equals `reqAddr[16:1]`. Bit 0 of the byte address selects the lane and never reaches the bus.
- R4: A write with `reqWord`=0 and `reqAddr[0]`=0 pulls only the low write strobe. With `reqAddr[0]`=1 it pulls only the high strobe. For both, `busDataOut` = {wdata[7:0], wdata[7:0]}. A write with `reqWord`=1 pulls both strobes, and `busDataOut` = wdata. `busDataOe` is 1 only during a write's active phase.
- R5: A read holds the read strobe low for the whole active phase, and no write strobe goes low. The result is `busDataIn` for a word read, {8'h00, busDataIn[7:0]} for an even byte read and {8'h00, busDataIn[15:8]} for an odd byte read.
- R6: The select stays low for exactly W+1 clocks. W is bits [4s+3:4s] of `cfgWait` for select s.
- R7: After the select rises, `reqReady` stays 0 for exactly R clocks. R is bits [4s+3:4s] of `cfgRecov` for the select just used.
- R8: Read data is sampled at the clock edge that ends the active phase. `rspValid` is high for one clock, the first clock with the select high again, and `rspRdata` is valid in that clock.
- R9: Address, strobes, selects and write data do not change while the select is low.
- R10: `reqReady` is 0 from the clock edge that accepts a request until recovery ends. A request held at `reqValid`=1 during that time does not start a cycle, and all selects stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWait | input | 12 | Per-select wait-state counts, 4 bits each, select 0 in the low bits |
| cfgRecov | input | 12 | Per-select recovery counts, 4 bits each, select 0 in the low bits |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request; a request is accepted when this and reqValid are both 1 at a clock edge |
| reqSel | input | 2 | Select index 0..2 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 16 | Write data (byte writes use bits 7..0) |
| rspValid | output | 1 | One-clock pulse when a cycle completes |
| rspRdata | output | 16 | Aligned read result |
| busSelN | output | 3 | Active-low card selects |
| busRdN | output | 1 | Active-low read strobe |
| busLwrN | output | 1 | Active-low low-byte write strobe |
| busHwrN | output | 1 | Active-low high-byte write strobe |
| busAddr | output | 16 | Word address |
| busDataOut | output | 16 | Data driven to the bus |
| busDataOe | output | 1 | Enable for busDataOut |
| busDataIn | input | 16 | Data read from the bus |

## Verification
The bench sets W=0 with R=0 to test the shortest cycle. A counter that reloads wrongly would stretch that cycle or skip recovery. W=15 with R=15 tests the widest counts, where an off-by-one error would show as 17 or 15 active clocks. A full sweep of all 256 pairs of W and R catches a block that reads its timing from the wrong select. Odd and even byte reads, taken at the top and bottom of the address space, catch a swapped lane or a shift that drops an address bit. The bench always raises the next request while recovery is still running, so a block that ignores `reqReady` would pull a select low too early and fail the recovery count.

// File: rtl/cs_bus_pkg.sv
package cs_bus_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;     // capture a new request
    logic capture;  // last active clock: sample read data
    logic busOn;    // active phase in progress
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_RECOV  = 2'd2
  } seqState_t;

endpackage

// File: rtl/cs_bus_ctrl.sv
module cs_bus_ctrl
  import cs_bus_pkg::*;
#(
  parameter int NUM_SEL = 3,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [SEL_W-1:0] reqSel,
  input  logic [SEL_W-1:0] curSel,
  input  logic [CNT_W-1:0] waitTab [NUM_SEL],
  input  logic [CNT_W-1:0] recTab  [NUM_SEL],
  output dpCtl_t           ctl
);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] waitSel;
  logic [CNT_W-1:0] recSel;

  // Timing for the incoming request comes from its own select; recovery
  // uses the select that owns the cycle now ending.
  always_comb begin
    waitSel = (int'(reqSel) < NUM_SEL) ? waitTab[reqSel] : '0;
    recSel  = (int'(curSel) < NUM_SEL) ? recTab[curSel]  : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_ACTIVE;
          cnt   <= waitSel;
        end
        ST_ACTIVE: if (cnt == '0) begin
          if (recSel == '0) state <= ST_IDLE;
          else begin
            state <= ST_RECOV;
            cnt   <= recSel - 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        ST_RECOV: if (cnt == '0) state <= ST_IDLE;
                  else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady    = (state == ST_IDLE);
    ctl.load    = (state == ST_IDLE) && reqValid;
    ctl.capture = (state == ST_ACTIVE) && (cnt == '0);
    ctl.busOn   = (state == ST_ACTIVE);
  end

  // R6: the active phase ends on the clock after the count reaches zero
  a_r6_active_ends: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && cnt == '0) |=> (state != ST_ACTIVE));

  // R7: recovery always hands back to idle, never straight to a new cycle
  a_r7_recov_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOV && cnt == '0) |=> (state == ST_IDLE));

endmodule

// File: rtl/cs_bus_dp.sv
module cs_bus_dp
  import cs_bus_pkg::*;
#(
  parameter int NUM_SEL = 3,
  parameter int SEL_W   = 2,
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [SEL_W-1:0]  curSel,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [NUM_SEL-1:0] busSelN,
  output logic              busRdN,
  output logic              busLwrN,
  output logic              busHwrN,
  output logic [ADDR_W-2:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn
);

  localparam int BYTE_W = DATA_W / 2;

  logic              isRdQ, wordQ, oddQ;
  logic              laneLo, laneHi;
  logic [DATA_W-1:0] aligned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSel     <= '0;
      busAddr    <= '0;
      busDataOut <= '0;
      isRdQ      <= 1'b1;
      wordQ      <= 1'b0;
      oddQ       <= 1'b0;
      rspValid   <= 1'b0;
      rspRdata   <= '0;
    end else begin
      if (ctl.load) begin
        curSel     <= reqSel;
        busAddr    <= reqAddr[ADDR_W-1:1];
        isRdQ      <= !reqWrite;
        wordQ      <= reqWord;
        oddQ       <= reqAddr[0];
        busDataOut <= reqWord ? reqWdata : {2{reqWdata[BYTE_W-1:0]}};
      end
      rspValid <= ctl.capture;
      if (ctl.capture) rspRdata <= aligned;
    end
  end

  always_comb begin
    laneLo  = wordQ || !oddQ;
    laneHi  = wordQ || oddQ;
    aligned = wordQ ? busDataIn
            : {{BYTE_W{1'b0}}, (oddQ ? busDataIn[DATA_W-1:BYTE_W] : busDataIn[BYTE_W-1:0])};
    busRdN    = !(ctl.busOn && isRdQ);
    busLwrN   = !(ctl.busOn && !isRdQ && laneLo);
    busHwrN   = !(ctl.busOn && !isRdQ && laneHi);
    busDataOe = ctl.busOn && !isRdQ;
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign busSelN[i] = !(ctl.busOn && (int'(curSel) == i));
  end

  // R2: never more than one select low
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~busSelN));

  // R5: a read never pulls a write strobe
  a_r5_read_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> (busLwrN && busHwrN));

endmodule

// File: rtl/cs_bus_master.sv
module cs_bus_master
  import cs_bus_pkg::*;
#(
  parameter int NUM_SEL = 3,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 16,
  localparam int SEL_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SEL*CNT_W-1:0] cfgWait,
  input  logic [NUM_SEL*CNT_W-1:0] cfgRecov,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [SEL_W-1:0]         reqSel,
  input  logic                     reqWrite,
  input  logic                     reqWord,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspRdata,
  output logic [NUM_SEL-1:0]       busSelN,
  output logic                     busRdN,
  output logic                     busLwrN,
  output logic                     busHwrN,
  output logic [ADDR_W-2:0]        busAddr,
  output logic [DATA_W-1:0]        busDataOut,
  output logic                     busDataOe,
  input  logic [DATA_W-1:0]        busDataIn
);

  logic [CNT_W-1:0] waitTab [NUM_SEL];
  logic [CNT_W-1:0] recTab  [NUM_SEL];
  logic [SEL_W-1:0] curSel;
  dpCtl_t           ctl;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_cfg
    assign waitTab[i] = cfgWait[i*CNT_W +: CNT_W];
    assign recTab[i]  = cfgRecov[i*CNT_W +: CNT_W];
  end

  cs_bus_ctrl #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSel(reqSel), .curSel(curSel), .waitTab(waitTab), .recTab(recTab),
    .ctl(ctl)
  );

  cs_bus_dp #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqSel(reqSel), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata), .curSel(curSel),
    .rspValid(rspValid), .rspRdata(rspRdata), .busSelN(busSelN), .busRdN(busRdN),
    .busLwrN(busLwrN), .busHwrN(busHwrN), .busAddr(busAddr),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn)
  );

  // R10: no request can be taken while a select is low
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !(&busSelN) |-> !reqReady);

  // R9: address held while the select stays low
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(&busSelN) && !$past(&busSelN)) |-> $stable(busAddr));

  // R8: completion pulse only in the first clock after a select rises
  a_r8_rsp_at_release: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((&busSelN) && !$past(&busSelN)));

endmodule

// File: tb/tb_cs_bus_master.sv
module tb_cs_bus_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] cfgWait = '0, cfgRecov = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic        reqReady, rspValid;
  logic [1:0]  reqSel = '0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, rspRdata;
  logic [2:0]  busSelN;
  logic        busRdN, busLwrN, busHwrN, busDataOe;
  logic [15:0] busAddr, busDataOut, busDataIn;

  int vectors = 0, errors = 0, prevRec = 0;
  int waitCfg [3], recCfg [3];
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Bus-side card model: read data is a fixed function of the word address.
  assign busDataIn = busRdN ? 16'hFFFF : {busAddr[7:0] ^ 8'h5A, busAddr[15:8] ^ busAddr[7:0]};

  cs_bus_master dut (
    .clk(clk), .rstN(rstN), .cfgWait(cfgWait), .cfgRecov(cfgRecov),
    .reqValid(reqValid), .reqReady(reqReady), .reqSel(reqSel), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspRdata(rspRdata), .busSelN(busSelN), .busRdN(busRdN), .busLwrN(busLwrN),
    .busHwrN(busHwrN), .busAddr(busAddr), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setCfg();
    for (int s = 0; s < 3; s++) begin
      cfgWait[s*4 +: 4]  = waitCfg[s][3:0];
      cfgRecov[s*4 +: 4] = recCfg[s][3:0];
    end
  endtask

  // Called at a negedge; returns at the negedge where the select is high again.
  task automatic runTxn(input int sel, input logic [16:0] addr, input bit wr,
                        input bit word, input logic [15:0] wd);
    int gap, act, w;
    logic [15:0] m, expRd, expBus, a0, d0;
    logic [2:0] expSel, st0;
    logic expLw, expHw;
    w = waitCfg[sel];
    m = {addr[8:1] ^ 8'h5A, addr[16:9] ^ addr[8:1]};
    expRd  = word ? m : {8'h00, (addr[0] ? m[15:8] : m[7:0])};
    expBus = word ? wd : {wd[7:0], wd[7:0]};
    expSel = ~(3'b001 << sel);
    expLw  = !(wr && (word || !addr[0]));
    expHw  = !(wr && (word || addr[0]));
    reqValid = 1'b1; reqSel = sel[1:0]; reqAddr = addr;
    reqWrite = wr; reqWord = word; reqWdata = wd;
    gap = 0;
    while (!reqReady && gap < 40) begin
      if (busSelN !== 3'b111) chk(1'b0, "R10 select low while held off", busSelN, 3'b111);
      gap++;
      @(negedge clk);
    end
    chk(gap == prevRec, "R7 recovery length", gap, prevRec);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busSelN === expSel, "R2 select pattern", busSelN, expSel);
    chk(busAddr === addr[16:1], "R3 word address", busAddr, addr[16:1]);
    chk(busRdN === wr, "R5 read strobe", busRdN, wr);
    chk({busLwrN, busHwrN} === {expLw, expHw}, "R4 write strobes", {busLwrN, busHwrN}, {expLw, expHw});
    chk(busDataOe === wr, "R4 data enable", busDataOe, wr);
    if (wr) chk(busDataOut === expBus, "R4 lane data", busDataOut, expBus);
    chk(rspValid === 1'b0, "R8 no early response", rspValid, 0);
    a0 = busAddr; d0 = busDataOut; st0 = {busRdN, busLwrN, busHwrN};
    act = 0;
    while (busSelN !== 3'b111 && act < 40) begin
      act++;
      if (busAddr !== a0 || {busRdN, busLwrN, busHwrN} !== st0 ||
          (wr && busDataOut !== d0) || busSelN !== expSel)
        chk(1'b0, "R9 held during active phase", {busAddr, 5'b0, busRdN, busLwrN, busHwrN},
            {a0, 5'b0, st0});
      @(negedge clk);
    end
    chk(act == w + 1, "R6 active length", act, w + 1);
    chk(rspValid === 1'b1, "R8 response pulse", rspValid, 1);
    if (!wr) chk(rspRdata === expRd, "R5 aligned read data", rspRdata, expRd);
    prevRec = recCfg[sel];
  endtask

  task automatic idleWait();
    repeat (18) @(negedge clk);
    prevRec = 0;
  endtask

  function automatic logic [16:0] pickAddr(input logic [16:0] a, input int ty);
    if (ty == 0 || ty == 3) return {a[16:1], 1'b0};
    if (ty == 1 || ty == 4) return {a[16:1], 1'b1};
    return a;
  endfunction

  initial begin
    logic [16:0] addrs [5];
    addrs = '{17'h00000, 17'h00001, 17'h1ABC5, 17'h1FFFF, 17'h0FF32};
    waitCfg = '{0, 3, 15};
    recCfg  = '{0, 2, 15};
    setCfg();
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(busSelN === 3'b111 && busRdN && busLwrN && busHwrN, "R1 strobes in reset",
        {busSelN, busRdN, busLwrN, busHwrN}, 6'h3F);
    chk(busDataOe === 1'b0 && rspValid === 1'b0, "R1 enables in reset", {busDataOe, rspValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1 && busSelN === 3'b111, "R1 idle after reset", {reqReady, busSelN}, 4'hF);

    // Every access type, on every select, at corner addresses.
    for (int s = 0; s < 3; s++)
      for (int ty = 0; ty < 6; ty++)
        for (int k = 0; k < 5; k++)
          runTxn(s, pickAddr(addrs[k], ty), ty >= 3, (ty % 3) == 2,
                 16'hC3A5 ^ 16'(k * 16'h1357) ^ 16'(ty));

    // Sweep of all wait and recovery pairs, two back-to-back cycles each.
    for (int w = 0; w < 16; w++)
      for (int r = 0; r < 16; r++) begin
        int s, ty;
        logic [16:0] a;
        idleWait();
        s = (w + r) % 3;
        ty = (w * 3 + r) % 6;
        waitCfg[s] = w; recCfg[s] = r;
        setCfg();
        a = 17'((w * 4099 + r * 257 + 1) & 17'h1FFFF);
        runTxn(s, pickAddr(a, ty), ty >= 3, (ty % 3) == 2, 16'(w * 16'h1111 + r));
        runTxn(s, pickAddr(a ^ 17'h0AAAB, 5 - ty), ty < 3, (ty % 3) == 2, 16'(r * 16'h0F0F + w));
      end

    idleWait();
    chk(busSelN === 3'b111 && reqReady === 1'b1, "R1 idle at end", {reqReady, busSelN}, 4'hF);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule